// File: doc/BRIEF.md
# Run Length Adaptation Unit

A flow that alternates between routes sends a run of packets on one route and then stops until the destination confirms that the run has arrived. The time spent sending is the on time. The time spent waiting for the confirmation is the off time. This unit runs once for each returning confirmation. It takes the two measured times and the flow's current average run length N, and it returns a new N. The aim is to keep the off-to-on ratio inside a band set by a lower threshold L = 2^L_SHIFT and an upper threshold H = 2^H_SHIFT, with H greater than L.

When waiting dominates (L·off > on), N grows by the smallest power of two that brings L·off/on down to one or less. When sending dominates (H·off < on), N shrinks by the smallest power of two that brings on/(H·off) down to one or less. Inside the band, N is kept as it is. Both multiplication and division are shifts. The exponent is found exactly with a bank of shifted comparisons, and no divider is used. The result saturates at the top of the N field and never falls below one.

The unit is a three-stage pipeline. It accepts a request on every cycle and answers each request with a one-cycle done pulse.

Top module: `run_len_adapt`

## Requirements
- R1: While reset is held and after it is released with no request, `done_o` is 0 and `n_new_o` is 0.
- R2: A request sampled on a rising edge with `upd_i`=1 produces `done_o`=1 for exactly one cycle, after the third rising edge counted from and including the sampling edge. `done_o` is never 1 without such a request.
- R3: When 2^L_SHIFT·off > on, the result is N·2^k, where k is the smallest integer with on·2^k ≥ 2^L_SHIFT·off. With the defaults, on=100, off=300, N=10 gives 80.
- R4: When 2^H_SHIFT·off < on, the result is floor(N/2^k), where k is the smallest integer with 2^H_SHIFT·off·2^k ≥ on.
- R5: When 2^L_SHIFT·off ≤ on ≤ 2^H_SHIFT·off, the result equals N. This includes both boundaries.
- R6: A grown result larger than 2^NW−1 is replaced by 2^NW−1 (32767 by default).
- R7: The result is never 0. A shrink that reaches 0 returns 1, and an N input of 0 is treated as 1.
- R8: An on time or off time of 0 is treated as 1.
- R9: Requests on consecutive cycles each produce their own correct result, on consecutive cycles and in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Request strobe, one per returning confirmation |
| on_time_i | input | TW | Cycles spent sending the last run |
| off_time_i | input | TW | Cycles spent waiting for the confirmation |
| n_cur_i | input | NW | Current average run length |
| n_new_o | output | NW | Adapted run length |
| done_o | output | 1 | One-cycle pulse marking `n_new_o` valid |

## Verification
The hardest situations to reach are those where the exponent lands exactly on a threshold boundary or runs to its extremes. One example is on exactly equal to H·off, which must be held, while on = H·off + 1 must shrink by one step. Another is a single-cycle on time against a very long off time, which drives the shift past the N field. The directed cases choose time pairs that sit exactly on each boundary and just past it. They also pair an extreme ratio with a small N to force saturation, and a deep shrink on a small N to force the floor of one. Three requests are issued back to back so that the stage registers hold different requests at the same time.

// File: rtl/run_len_adapt_pkg.sv
package run_len_adapt_pkg;

  // Direction chosen for a request after comparing the ratio with the band
  typedef enum logic [1:0] {
    ADJ_HOLD   = 2'd0,
    ADJ_GROW   = 2'd1,
    ADJ_SHRINK = 2'd2
  } adj_dir_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rla_classify.sv
// Stage 1: clamp the inputs, place the ratio against the band,
// and pick the numerator and denominator whose ratio sets the exponent.
module rla_classify
  import run_len_adapt_pkg::*;
#(
  parameter int unsigned TW      = 16,
  parameter int unsigned NW      = 15,
  parameter int unsigned L_SHIFT = 1,
  parameter int unsigned H_SHIFT = 3,
  parameter int unsigned OW      = TW + max_u(L_SHIFT, H_SHIFT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] off_i,
  input  logic [NW-1:0] n_i,
  output logic          vld_o,
  output adj_dir_e      dir_o,
  output logic [OW-1:0] num_o,
  output logic [OW-1:0] den_o,
  output logic [NW-1:0] n_o
);

  logic [TW-1:0] on_c, off_c;
  logic [NW-1:0] n_c;
  logic [OW-1:0] on_w, lo_w, hi_w;
  adj_dir_e      dir_d;
  logic [OW-1:0] num_d, den_d;

  always_comb begin
    on_c  = (on_i  == '0) ? TW'(1) : on_i;
    off_c = (off_i == '0) ? TW'(1) : off_i;
    n_c   = (n_i   == '0) ? NW'(1) : n_i;
    on_w  = OW'(on_c);
    lo_w  = OW'(off_c) << L_SHIFT;
    hi_w  = OW'(off_c) << H_SHIFT;
    dir_d = ADJ_HOLD;
    num_d = on_w;
    den_d = on_w;
    if (lo_w > on_w) begin
      dir_d = ADJ_GROW;
      num_d = lo_w;
      den_d = on_w;
    end else if (hi_w < on_w) begin
      dir_d = ADJ_SHRINK;
      num_d = on_w;
      den_d = hi_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dir_o <= ADJ_HOLD;
      num_o <= '0;
      den_o <= '0;
      n_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        dir_o <= dir_d;
        num_o <= num_d;
        den_o <= den_d;
        n_o   <= n_c;
      end
    end
  end

  // Outside the band the numerator always exceeds the denominator
  AST_RATIO_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && dir_o != ADJ_HOLD) |-> (num_o > den_o)); // R3

  // A clamped N never reaches the later stages as zero
  AST_N_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (n_o != '0)); // R7

endmodule

// File: rtl/rla_ceil_log2.sv
// Stage 2: k = smallest integer with den * 2^k >= num, found from a
// monotone set of shifted comparisons (the count of the ones that fail).
module rla_ceil_log2
  import run_len_adapt_pkg::*;
#(
  parameter int unsigned OW   = 19,
  parameter int unsigned NW   = 15,
  parameter int unsigned KMAX = 19,
  parameter int unsigned EW   = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  adj_dir_e      dir_i,
  input  logic [OW-1:0] num_i,
  input  logic [OW-1:0] den_i,
  input  logic [NW-1:0] n_i,
  output logic          vld_o,
  output adj_dir_e      dir_o,
  output logic [EW-1:0] exp_o,
  output logic [NW-1:0] n_o
);

  localparam int unsigned CW = OW + KMAX;

  logic [KMAX-1:0] below;
  logic [EW-1:0]   exp_d;

  for (genvar j = 0; j < KMAX; j++) begin : g_cmp
    logic [CW-1:0] den_sh;
    assign den_sh   = CW'(den_i) << j;
    assign below[j] = den_sh < CW'(num_i);
  end

  always_comb begin
    exp_d = '0;
    for (int j = 0; j < KMAX; j++) begin
      if (below[j]) exp_d = exp_d + EW'(1);
    end
    if (dir_i == ADJ_HOLD) exp_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dir_o <= ADJ_HOLD;
      exp_o <= '0;
      n_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        dir_o <= dir_d_q(dir_i);
        exp_o <= exp_d;
        n_o   <= n_i;
      end
    end
  end

  function automatic adj_dir_e dir_d_q(input adj_dir_e d);
    return d;
  endfunction

  // A grow or shrink always moves N by at least one step
  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && dir_o != ADJ_HOLD) |-> (exp_o != '0)); // R4

  // The comparison bank is monotone: once a step suffices, every larger one does
  AST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> $countones(below ^ (below & (below >> 1))) <= 1); // R3

endmodule

// File: rtl/rla_scale.sv
// Stage 3: shift N by the exponent, saturating upward and flooring at one.
module rla_scale
  import run_len_adapt_pkg::*;
#(
  parameter int unsigned NW   = 15,
  parameter int unsigned KMAX = 19,
  parameter int unsigned EW   = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  adj_dir_e      dir_i,
  input  logic [EW-1:0] exp_i,
  input  logic [NW-1:0] n_i,
  output logic          done_o,
  output logic [NW-1:0] n_o
);

  localparam int unsigned XW = NW + KMAX + 1;
  localparam logic [NW-1:0] NMAX = '1;

  logic [XW-1:0] up_w;
  logic [NW-1:0] dn_w;
  logic [NW-1:0] n_d;

  always_comb begin
    up_w = XW'(n_i) << exp_i;
    dn_w = n_i >> exp_i;
    unique case (dir_i)
      ADJ_GROW:   n_d = (up_w > XW'(NMAX)) ? NMAX : up_w[NW-1:0];
      ADJ_SHRINK: n_d = (dn_w == '0) ? NW'(1) : dn_w;
      default:    n_d = n_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      n_o    <= '0;
    end else begin
      done_o <= vld_i;
      if (vld_i) n_o <= n_d;
    end
  end

  AST_GROW_NOT_SMALLER: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && dir_i == ADJ_GROW) |=> (n_o >= $past(n_i))); // R6

  AST_SHRINK_NOT_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && dir_i == ADJ_SHRINK) |=> (n_o <= $past(n_i))); // R4

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && dir_i == ADJ_HOLD) |=> (n_o == $past(n_i))); // R5

  AST_RESULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (n_o != '0)); // R7

endmodule

// File: rtl/run_len_adapt.sv
module run_len_adapt
  import run_len_adapt_pkg::*;
#(
  parameter int unsigned TW      = 16,
  parameter int unsigned NW      = 15,
  parameter int unsigned L_SHIFT = 1,
  parameter int unsigned H_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic [TW-1:0] on_time_i,
  input  logic [TW-1:0] off_time_i,
  input  logic [NW-1:0] n_cur_i,
  output logic [NW-1:0] n_new_o,
  output logic          done_o
);

  localparam int unsigned MSH  = max_u(L_SHIFT, H_SHIFT);
  localparam int unsigned OW   = TW + MSH;
  localparam int unsigned KMAX = TW + MSH;
  localparam int unsigned EW   = $clog2(KMAX + 1);

  // Reset asserts at once and is released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic          s1_vld, s2_vld;
  adj_dir_e      s1_dir, s2_dir;
  logic [OW-1:0] s1_num, s1_den;
  logic [NW-1:0] s1_n, s2_n;
  logic [EW-1:0] s2_exp;

  rla_classify #(
    .TW(TW), .NW(NW), .L_SHIFT(L_SHIFT), .H_SHIFT(H_SHIFT), .OW(OW)
  ) u_classify (
    .clk(clk), .rst_n(rst_q), .vld_i(upd_i),
    .on_i(on_time_i), .off_i(off_time_i), .n_i(n_cur_i),
    .vld_o(s1_vld), .dir_o(s1_dir), .num_o(s1_num), .den_o(s1_den), .n_o(s1_n)
  );

  rla_ceil_log2 #(
    .OW(OW), .NW(NW), .KMAX(KMAX), .EW(EW)
  ) u_log2 (
    .clk(clk), .rst_n(rst_q), .vld_i(s1_vld), .dir_i(s1_dir),
    .num_i(s1_num), .den_i(s1_den), .n_i(s1_n),
    .vld_o(s2_vld), .dir_o(s2_dir), .exp_o(s2_exp), .n_o(s2_n)
  );

  rla_scale #(
    .NW(NW), .KMAX(KMAX), .EW(EW)
  ) u_scale (
    .clk(clk), .rst_n(rst_q), .vld_i(s2_vld), .dir_i(s2_dir),
    .exp_i(s2_exp), .n_i(s2_n), .done_o(done_o), .n_o(n_new_o)
  );

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> $past(upd_i, 3)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    (done_o && !$past(upd_i, 2)) |=> !done_o); // R2

endmodule

// File: tb/tb_run_len_adapt.sv
module tb_run_len_adapt;

  localparam int TW = 16;
  localparam int NW = 15;

  logic          clk;
  logic          rst_n;
  logic          upd;
  logic [TW-1:0] on_t, off_t;
  logic [NW-1:0] n_cur;
  logic [NW-1:0] n_new;
  logic          done;

  int n_chk;
  int n_bad;

  run_len_adapt #(.TW(TW), .NW(NW), .L_SHIFT(1), .H_SHIFT(3)) dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .on_time_i(on_t),
    .off_time_i(off_t), .n_cur_i(n_cur), .n_new_o(n_new), .done_o(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One request; result checked after the third edge, pulse end checked one cycle later
  task automatic run_case(input string req, input int on, input int off,
                          input int n, input int exp);
    @(negedge clk);
    upd = 1'b1; on_t = TW'(on); off_t = TW'(off); n_cur = NW'(n);
    @(negedge clk);
    upd = 1'b0;
    chk({req, " no early done"}, int'(done), 0);
    @(negedge clk);
    @(negedge clk);
    chk({req, " done"}, int'(done), 1);
    chk({req, " value"}, int'(n_new), exp);
    @(negedge clk);
    chk("R2 pulse width", int'(done), 0);
  endtask

  task automatic test_reset();
    upd = 1'b0; on_t = '0; off_t = '0; n_cur = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 value in reset", int'(n_new), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 done idle", int'(done), 0);
    chk("R2 no request no done", int'(done), 0);
    chk("R1 value idle", int'(n_new), 0);
  endtask

  task automatic test_grow();
    run_case("R3 grow k1", 100, 100, 64, 128);
    run_case("R3 grow k3", 100, 300, 10, 80);
  endtask

  task automatic test_shrink();
    run_case("R4 shrink just past edge", 801, 100, 40, 20);
    run_case("R4 shrink k4", 1000, 10, 1000, 62);
  endtask

  task automatic test_hold();
    run_case("R5 hold at lower edge", 100, 50, 10, 10);
    run_case("R5 hold at upper edge", 800, 100, 40, 40);
  endtask

  task automatic test_saturate();
    run_case("R6 saturate large ratio", 1, 1000, 100, 32767);
    run_case("R6 saturate at max N", 100, 100, 32767, 32767);
    run_case("R6 extreme ratio", 1, 65535, 1, 32767);
  endtask

  task automatic test_floor();
    run_case("R7 deep shrink floors at one", 60000, 1, 3, 1);
    run_case("R7 zero N held as one", 100, 40, 0, 1);
  endtask

  task automatic test_zero_times();
    run_case("R8 both zero", 0, 0, 50, 100);
    run_case("R8 zero on", 0, 5, 7, 112);
    run_case("R8 zero off", 100, 0, 64, 4);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    upd = 1'b1; on_t = 16'd100;  off_t = 16'd100; n_cur = 15'd64;
    @(negedge clk);
    on_t = 16'd100;  off_t = 16'd300; n_cur = 15'd10;
    @(negedge clk);
    on_t = 16'd1000; off_t = 16'd10;  n_cur = 15'd1000;
    @(negedge clk);
    upd = 1'b0;
    chk("R9 first done", int'(done), 1);
    chk("R9 first value", int'(n_new), 128);
    @(negedge clk);
    chk("R9 second done", int'(done), 1);
    chk("R9 second value", int'(n_new), 80);
    @(negedge clk);
    chk("R9 third done", int'(done), 1);
    chk("R9 third value", int'(n_new), 62);
    @(negedge clk);
    chk("R9 train ends", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    test_reset();
    test_grow();
    test_shrink();
    test_hold();
    test_saturate();
    test_floor();
    test_zero_times();
    test_back_to_back();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule